// File: doc/BRIEF.md
# Programmable Pin-to-Control Router

Eight general-purpose input pins, numbered 0 to 7, can each be steered onto one of a fixed set of internal control lines. Every pin owns an 8-bit configuration byte written through a small address/data/write-enable port. When the top bit of that byte is clear, the low seven bits are a function code that names the control line the pin drives. When the top bit is set, the pin is not an input here and drives nothing.

The router resynchronises the raw pins through two flops and decodes all eight function codes in parallel. Where several pins claim the same control line, it lets only the lowest-numbered of them drive it. Every control line has its own register. A line that no pin claims is held at 0.

The control lines fall into six groups:
- five system strobes: I/O update, full power-down, watchdog reset, interrupt reset and tuning-history reset;
- five loop controls: holdover, free run, phase-offset reset, phase-offset increment and phase-offset decrement;
- eight reference-monitor overrides;
- eight forced validation timeouts;
- four output enables;
- one output-sync line.

Top module: `pin_ctl_router`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` as the configuration byte of pin `cfg_addr`. After reset every configuration byte is 0.
- R2: A pin whose configuration bit 7 is 1 drives no control line, whatever its low seven bits hold.
- R3: Some function codes are unused and drive nothing: 0 (the reset default), 6–15, 21–31, 40–47, 56–63 and 70–127.
- R4: Codes 1 to 5 drive the system strobes in order: `sys_ctl[0]` I/O update, `[1]` full power-down, `[2]` watchdog reset, `[3]` interrupt reset and `[4]` tuning-history reset.
- R5: Codes 16 to 20 drive the loop controls in order: `loop_ctl[0]` holdover, `[1]` free run, `[2]` phase-offset reset, `[3]` phase-offset increment and `[4]` phase-offset decrement.
- R6: Code 32+k (k = 0..7) drives `ref_ovr[k]`. Code 48+k drives `vto_force[k]`.
- R7: Code 64+k (k = 0..3) drives `out_en[k]` alone. Code 68 drives all four `out_en` bits. Code 69 drives `out_sync`.
- R8: When two or more pins select the same control line, that line follows the lowest-numbered of those pins and ignores the others. This also holds when code 68 and a single-enable code meet on one `out_en` bit.
- R9: A control line that no pin selects is 0. Every output is 0 during reset.
- R10: A change on `pin_in` reaches the outputs on the third rising clock edge after it. A configuration write takes effect on the outputs one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Pin number to configure |
| cfg_wdata | input | 8 | Configuration byte: bit 7 = 1 disables input use, bits 6:0 = function code |
| pin_in | input | 8 | Asynchronous pin levels |
| sys_ctl | output | 5 | System strobes (codes 1–5) |
| loop_ctl | output | 5 | Loop controls (codes 16–20) |
| ref_ovr | output | 8 | Reference-monitor overrides (codes 32–39) |
| vto_force | output | 8 | Forced validation timeouts (codes 48–55) |
| out_en | output | 4 | Output enables (codes 64–68) |
| out_sync | output | 1 | Output sync (code 69) |

## Verification
The bench sweeps all 128 codes on one pin. A decoder with shifted range edges would light the wrong line, and one that treats the unused gaps carelessly would light a line where none is allowed. It then sets up colliding pins: a shared holdover code, and code 68 against single-enable codes in both priority orders. A priority encoder that picks the highest pin, or one that lets code 68 override a lower-numbered single enable, would give the wrong level. It also checks that a set bit 7 masks the pin, and it counts the pin-to-output and write-to-output latencies edge by edge, which catches a missing or extra register stage.

// File: rtl/pin_ctl_router.sv
module pin_ctl_router #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [4:0]        sys_ctl,
  output logic [4:0]        loop_ctl,
  output logic [7:0]        ref_ovr,
  output logic [7:0]        vto_force,
  output logic [3:0]        out_en,
  output logic              out_sync
);

  localparam int NCTL = 31;

  logic [7:0]      cfg_q [NPINS];
  logic [NPINS-1:0] pin_m, pin_s;
  logic [NCTL-1:0] claim [NPINS];
  logic [NCTL-1:0] any_claim, ctl_d, ctl_q;

  function automatic logic [NCTL-1:0] code_map(input logic [6:0] c);
    logic [NCTL-1:0] m;
    int ci;
    m  = '0;
    ci = int'(c);
    if (ci >= 1 && ci <= 5)        m[ci - 1]  = 1'b1;
    else if (ci >= 16 && ci <= 20) m[ci - 11] = 1'b1;
    else if (ci >= 32 && ci <= 39) m[ci - 22] = 1'b1;
    else if (ci >= 48 && ci <= 55) m[ci - 30] = 1'b1;
    else if (ci >= 64 && ci <= 67) m[ci - 38] = 1'b1;
    else if (ci == 68)             m[29:26]   = 4'hF;
    else if (ci == 69)             m[30]      = 1'b1;
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) cfg_q[p] <= '0;
    end else if (cfg_we && int'(cfg_addr) < NPINS) begin
      cfg_q[cfg_addr] <= cfg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_m <= '0;
      pin_s <= '0;
    end else begin
      pin_m <= pin_in;
      pin_s <= pin_m;
    end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign claim[p] = cfg_q[p][7] ? '0 : code_map(cfg_q[p][6:0]);
  end

  always_comb begin
    ctl_d     = '0;
    any_claim = '0;
    for (int p = NPINS - 1; p >= 0; p--) begin
      any_claim = any_claim | claim[p];
      for (int j = 0; j < NCTL; j++)
        if (claim[p][j]) ctl_d[j] = pin_s[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;

  assign sys_ctl   = ctl_q[4:0];
  assign loop_ctl  = ctl_q[9:5];
  assign ref_ovr   = ctl_q[17:10];
  assign vto_force = ctl_q[25:18];
  assign out_en    = ctl_q[29:26];
  assign out_sync  = ctl_q[30];

  a_r1_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q[$past(cfg_addr)] == $past(cfg_wdata)));

  a_r9_unclaimed_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~$past(any_claim)) == '0);

  a_r10_quiet_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_s) == '0) |-> (ctl_q == '0));

  a_r8_pin0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & $past(claim[0])) == ($past(claim[0]) & {NCTL{$past(pin_s[0])}}));

  a_r7_all_enables: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_q[0]) == 8'd68) |-> (out_en == {4{$past(pin_s[0])}}));

endmodule

// File: tb/test_pin_ctl_router.sv
module test_pin_ctl_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] pin_in = '0;
  logic [4:0] sys_ctl, loop_ctl;
  logic [7:0] ref_ovr, vto_force;
  logic [3:0] out_en;
  logic       out_sync;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] sh [8];
  logic [30:0] exp_q [$];
  string tag_q [$];
  event chk_ev;

  always #4 clk = ~clk;

  pin_ctl_router i_pin_ctl_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_in(pin_in), .sys_ctl(sys_ctl),
    .loop_ctl(loop_ctl), .ref_ovr(ref_ovr), .vto_force(vto_force),
    .out_en(out_en), .out_sync(out_sync));

  function automatic logic [30:0] outs();
    return {out_sync, out_en, vto_force, ref_ovr, loop_ctl, sys_ctl};
  endfunction

  function automatic logic [30:0] model();
    logic [30:0] e = '0;
    for (int p = 7; p >= 0; p--) begin
      if (!sh[p][7]) begin
        int c = int'(sh[p][6:0]);
        logic b = pin_in[p];
        case (c) inside
          [1:5]:   e[c - 1]  = b;
          [16:20]: e[c - 11] = b;
          [32:39]: e[10 + c - 32] = b;
          [48:55]: e[18 + c - 48] = b;
          [64:67]: e[26 + c - 64] = b;
          68:      e[29:26] = {4{b}};
          69:      e[30] = b;
          default: ;
        endcase
      end
    end
    return e;
  endfunction

  function automatic string code_tag(int c);
    if (c >= 1 && c <= 5) return "R4";
    if (c >= 16 && c <= 20) return "R5";
    if ((c >= 32 && c <= 39) || (c >= 48 && c <= 55)) return "R6";
    if (c >= 64 && c <= 69) return "R7";
    return "R3";
  endfunction

  task automatic check(logic [30:0] got, logic [30:0] exp, string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    sh[a] = d;
  endtask

  task automatic drive(logic [7:0] pins, string tag);
    @(negedge clk);
    pin_in = pins;
    repeat (4) @(negedge clk);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    -> chk_ev;
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      check(outs(), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : driver
    for (int p = 0; p < 8; p++) sh[p] = '0;
    pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    check(outs(), '0, "R9 outputs in reset");
    rst_n = 1'b1;
    drive(8'hFF, "R1 R3 reset config drives nothing");

    for (int c = 0; c < 128; c++) begin
      wr(3, 8'(c));
      drive(8'h08, code_tag(c));
      drive(8'hF7, code_tag(c));
    end
    wr(3, 8'h00);

    wr(0, 8'h81);
    drive(8'hFF, "R2 bit7 masks pin");
    wr(0, 8'h00);

    wr(2, 8'd16); wr(5, 8'd16);
    drive(8'h20, "R8 pin5 ignored");
    drive(8'h04, "R8 pin2 drives");
    wr(2, 8'h00); wr(5, 8'h00);

    wr(1, 8'd68); wr(4, 8'd65);
    drive(8'h02, "R8 code68 low pin wins");
    drive(8'h10, "R8 single enable loses");
    wr(1, 8'h00); wr(4, 8'h00);

    wr(2, 8'd65); wr(6, 8'd68);
    drive(8'h40, "R8 R9 single enable wins its bit");
    drive(8'h04, "R8 code68 fills rest");
    wr(2, 8'h00); wr(6, 8'h00);

    wr(0, 8'd1);
    drive(8'h00, "R10 setup");
    pin_in = 8'h01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(31'(sys_ctl[0]), 31'd0, "R10 no output after two edges");
    @(posedge clk); @(negedge clk);
    check(31'(sys_ctl[0]), 31'd1, "R10 output on third edge");

    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'd2;
    @(negedge clk);
    cfg_we = 1'b0; sh[0] = 8'd2;
    check(31'(sys_ctl[1:0]), 31'd1, "R10 R1 config not yet visible");
    @(negedge clk);
    check(31'(sys_ctl[1:0]), 31'd2, "R10 R1 config visible next edge");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule